// File: doc/BRIEF.md
# Serial Two-Wire Register-Write Target

This block is a target on a two-wire serial bus (I2C) that holds a small bank of byte-wide registers. It oversamples the bus clock and data lines with the system clock, finds the bus framing conditions, and checks the first byte of each transfer against its own 7-bit device address or the all-zero broadcast address. For a write transfer, the next byte loads a register pointer. Each byte after that is stored at the pointer, and the pointer then steps forward by one.

The block pulls the data line low only to acknowledge a byte. It never holds the clock low. When a byte would land beyond the last register, the block leaves the line high on the acknowledge clock and does not store the byte. Local logic reads any register at any time through a parallel index/data port.

Top module: `i2c_regfile_target`

## Requirements
- R1: Both bus lines pass through a two-flop synchroniser. A falling data line while the clock is high is a start condition. A rising data line while the clock is high is a stop condition. `bus_busy` goes high after a start and low after a stop.
- R2: Data bits are taken while the clock is high, most significant bit first, eight bits to a byte. In the first byte after a start, bits [7:1] are the device address and bit 0 is the direction (0 = write, 1 = read).
- R3: When the first byte carries the address DEV_ADDR, the target acknowledges it. To acknowledge, it pulls the data line low from the clock fall after the eighth bit until the clock fall after the ninth bit. The pull output changes only while the synchronised clock is low.
- R4: A first byte with any other address is not acknowledged. The target then ignores every byte until the next start condition.
- R5: Address 0 with direction bit 0 (broadcast write) is acknowledged and handled like a write to the target's own address.
- R6: The second byte of a write transfer loads the register pointer and is always acknowledged, whatever its value.
- R7: Each later byte is stored in the register the pointer names and is acknowledged, and the pointer then advances by one.
- R8: When the pointer is at or beyond NUM_REGS, a data byte is not acknowledged and no register changes.
- R9: A start condition in the middle of a transfer discards any partial byte and returns the target to the address byte.
- R10: A matching address with direction bit 1 is acknowledged. After that, the target drives nothing until the next start or stop condition.
- R11: After reset every register reads 0, the data line is released, and `bus_busy` is low.
- R12: `rd_data` shows the register selected by `rd_index` in the same cycle, with no clock delay.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| scl_in | input | 1 | Bus clock line as seen at the pad |
| sda_in | input | 1 | Bus data line as seen at the pad |
| sda_pull_low | output | 1 | 1 = drive the data line low (open-drain enable) |
| bus_busy | output | 1 | High from a start condition until a stop condition |
| rd_index | input | IDX_W (4) | Register selected for local read |
| rd_data | output | 8 | Contents of the selected register |

## Verification
The bench writes a burst that begins two registers before the end of the bank. A target that wraps the pointer would overwrite register 0, and one that keeps acknowledging would hide the overflow; the bench checks both. A second case sends a pointer byte that is already out of range, where a target that fails to acknowledge the pointer, or that stores the data byte, is caught. A repeated start arrives three bits into a byte. A target that kept those bits would misalign the next address byte and miss it. Other cases cover a foreign address, the broadcast address and a read-direction address. In each of these, a target that answers when it should stay silent, or stays silent when it should answer, shows up in the acknowledge scoreboard.

// File: rtl/i2c_tgt_pkg.sv
package i2c_tgt_pkg;

    localparam int BYTE_W   = 8;
    localparam int BITCNT_W = 4;
    localparam int PTR_W    = 9;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_ADDR,
        ST_PTR,
        ST_DATA,
        ST_SKIP
    } tgt_state_e;

    typedef struct packed {
        logic scl_hi;
        logic scl_rise;
        logic scl_fall;
        logic sda;
        logic start;
        logic stop;
    } bus_evt_t;

    typedef struct packed {
        logic hit;
        logic rd;
    } addr_dec_t;

    typedef struct packed {
        logic              en;
        logic [BYTE_W-1:0] idx;
        logic [BYTE_W-1:0] data;
    } wr_req_t;

    function automatic addr_dec_t decode_addr(input logic [BYTE_W-1:0] b,
                                              input logic [6:0]        own);
        addr_dec_t d;
        d.rd  = b[0];
        d.hit = (b[7:1] == own) || ((b[7:1] == 7'd0) && !b[0]);
        return d;
    endfunction

endpackage

// File: rtl/i2c_line_sync.sv
module i2c_line_sync
    import i2c_tgt_pkg::*;
#(
    parameter int STAGES = 2
) (
    input  logic     clk,
    input  logic     rst,
    input  logic     scl_in,
    input  logic     sda_in,
    output bus_evt_t evt
);

    localparam int LINES = 2;

    logic [LINES-1:0] raw;
    logic [LINES-1:0] cur;
    logic [LINES-1:0] prev;

    assign raw = {scl_in, sda_in};

    for (genvar g = 0; g < LINES; g++) begin : g_line
        logic [STAGES-1:0] chain;
        logic              last;
        always_ff @(posedge clk) begin
            if (rst) begin
                chain <= '1;
                last  <= 1'b1;
            end else begin
                chain <= {chain[STAGES-2:0], raw[g]};
                last  <= chain[STAGES-1];
            end
        end
        assign cur[g]  = chain[STAGES-1];
        assign prev[g] = last;
    end

    always_comb begin
        evt.scl_hi   = cur[1];
        evt.sda      = cur[0];
        evt.scl_rise = cur[1] && !prev[1];
        evt.scl_fall = !cur[1] && prev[1];
        evt.start    = cur[1] && prev[1] && prev[0] && !cur[0];
        evt.stop     = cur[1] && prev[1] && !prev[0] && cur[0];
    end

endmodule

// File: rtl/i2c_target_ctrl.sv
module i2c_target_ctrl
    import i2c_tgt_pkg::*;
#(
    parameter logic [6:0] DEV_ADDR = 7'h2A,
    parameter int         NUM_REGS = 16
) (
    input  logic     clk,
    input  logic     rst,
    input  bus_evt_t evt,
    output logic     pull,
    output logic     busy,
    output wr_req_t  wr
);

    localparam logic [PTR_W-1:0]    LAST_PTR = PTR_W'(NUM_REGS);
    localparam logic [BITCNT_W-1:0] FULL_CNT = BITCNT_W'(BYTE_W);

    tgt_state_e          state;
    logic [BITCNT_W-1:0] bit_cnt;
    logic [BYTE_W-1:0]   shreg;
    logic [PTR_W-1:0]    ptr;
    logic                in_ack;
    addr_dec_t           dec_now;
    logic                ptr_ok;

    always_comb begin
        dec_now = decode_addr(shreg, DEV_ADDR);
        ptr_ok  = ptr < LAST_PTR;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            state   <= ST_IDLE;
            bit_cnt <= '0;
            shreg   <= '0;
            ptr     <= '0;
            in_ack  <= 1'b0;
            pull    <= 1'b0;
            busy    <= 1'b0;
            wr      <= '0;
        end else begin
            wr.en <= 1'b0;
            if (evt.start) begin
                state   <= ST_ADDR;
                bit_cnt <= '0;
                in_ack  <= 1'b0;
                pull    <= 1'b0;
                busy    <= 1'b1;
            end else if (evt.stop) begin
                state   <= ST_IDLE;
                bit_cnt <= '0;
                in_ack  <= 1'b0;
                pull    <= 1'b0;
                busy    <= 1'b0;
            end else if (evt.scl_fall && in_ack) begin
                in_ack  <= 1'b0;
                pull    <= 1'b0;
                bit_cnt <= '0;
            end else if (state == ST_ADDR || state == ST_PTR || state == ST_DATA) begin
                if (evt.scl_rise && !in_ack && bit_cnt < FULL_CNT) begin
                    shreg   <= {shreg[BYTE_W-2:0], evt.sda};
                    bit_cnt <= bit_cnt + 1'b1;
                end else if (evt.scl_fall && bit_cnt == FULL_CNT) begin
                    unique case (state)
                        ST_ADDR: begin
                            if (dec_now.hit) begin
                                in_ack <= 1'b1;
                                pull   <= 1'b1;
                                state  <= dec_now.rd ? ST_SKIP : ST_PTR;
                            end else begin
                                state  <= ST_SKIP;
                            end
                        end
                        ST_PTR: begin
                            in_ack <= 1'b1;
                            pull   <= 1'b1;
                            ptr    <= {1'b0, shreg};
                            state  <= ST_DATA;
                        end
                        default: begin
                            in_ack <= 1'b1;
                            if (ptr_ok) begin
                                pull    <= 1'b1;
                                wr.en   <= 1'b1;
                                wr.idx  <= ptr[BYTE_W-1:0];
                                wr.data <= shreg;
                                ptr     <= ptr + 1'b1;
                            end
                        end
                    endcase
                end
            end
        end
    end

    a_r1_busy_after_start: assert property (@(posedge clk) disable iff (rst)
        evt.start |=> busy);

    a_r1_idle_after_stop: assert property (@(posedge clk) disable iff (rst)
        evt.stop |=> !busy);

    a_r3_pull_moves_scl_low: assert property (@(posedge clk) disable iff (rst)
        !$stable(pull) |-> !$past(evt.scl_hi));

    a_r8_write_in_range: assert property (@(posedge clk) disable iff (rst)
        wr.en |-> (int'(wr.idx) < NUM_REGS));

    a_r9_start_to_addr: assert property (@(posedge clk) disable iff (rst)
        evt.start |=> (state == ST_ADDR && bit_cnt == '0));

    a_r10_skip_silent: assert property (@(posedge clk) disable iff (rst)
        (state == ST_SKIP && !in_ack) |-> !pull);

endmodule

// File: rtl/i2c_reg_bank.sv
module i2c_reg_bank
    import i2c_tgt_pkg::*;
#(
    parameter int NUM_REGS = 16,
    parameter int IDX_W    = 4
) (
    input  logic              clk,
    input  logic              rst,
    input  wr_req_t           wr,
    input  logic [IDX_W-1:0]  rd_index,
    output logic [BYTE_W-1:0] rd_data
);

    logic [BYTE_W-1:0] regs [NUM_REGS];

    for (genvar i = 0; i < NUM_REGS; i++) begin : g_reg
        logic [BYTE_W-1:0] q;
        always_ff @(posedge clk) begin
            if (rst)
                q <= '0;
            else if (wr.en && int'(wr.idx) == i)
                q <= wr.data;
        end
        assign regs[i] = q;
    end

    if (NUM_REGS == (1 << IDX_W)) begin : g_full_rd
        assign rd_data = regs[rd_index];
    end else begin : g_part_rd
        always_comb begin
            rd_data = '0;
            if (int'(rd_index) < NUM_REGS)
                rd_data = regs[rd_index];
        end
    end

    a_r7_write_lands: assert property (@(posedge clk) disable iff (rst)
        wr.en |=> (regs[$past(wr.idx[IDX_W-1:0])] == $past(wr.data)));

endmodule

// File: rtl/i2c_regfile_target.sv
module i2c_regfile_target
    import i2c_tgt_pkg::*;
#(
    parameter logic [6:0] DEV_ADDR = 7'h2A,
    parameter int         NUM_REGS = 16,
    parameter int         IDX_W    = $clog2(NUM_REGS)
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              scl_in,
    input  logic              sda_in,
    output logic              sda_pull_low,
    output logic              bus_busy,
    input  logic [IDX_W-1:0]  rd_index,
    output logic [BYTE_W-1:0] rd_data
);

    bus_evt_t evt;
    wr_req_t  wr;

    i2c_line_sync #(.STAGES(2)) u_sync (
        .clk    (clk),
        .rst    (rst),
        .scl_in (scl_in),
        .sda_in (sda_in),
        .evt    (evt)
    );

    i2c_target_ctrl #(.DEV_ADDR(DEV_ADDR), .NUM_REGS(NUM_REGS)) u_ctrl (
        .clk  (clk),
        .rst  (rst),
        .evt  (evt),
        .pull (sda_pull_low),
        .busy (bus_busy),
        .wr   (wr)
    );

    i2c_reg_bank #(.NUM_REGS(NUM_REGS), .IDX_W(IDX_W)) u_bank (
        .clk      (clk),
        .rst      (rst),
        .wr       (wr),
        .rd_index (rd_index),
        .rd_data  (rd_data)
    );

    a_r3_no_pull_idle: assert property (@(posedge clk) disable iff (rst)
        !bus_busy |-> !sda_pull_low);

endmodule

// File: tb/sim_i2c_regfile_target.sv
`timescale 1ns/1ps
module sim_i2c_regfile_target;

    localparam int Q = 10;
    localparam int NREG = 16;
    localparam logic [6:0] ADDR = 7'h2A;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       scl_m = 1'b1;
    logic       sda_m = 1'b1;
    logic       sda_bus;
    logic       pull;
    logic       busy;
    logic [3:0] rd_index = '0;
    logic [7:0] rd_data;

    int checks = 0;
    int errors = 0;
    logic [7:0] model [NREG];

    logic  exp_q [$];
    logic  got_q [$];
    string tag_q [$];

    always #2 clk = ~clk;

    assign sda_bus = sda_m & ~pull;

    i2c_regfile_target #(.DEV_ADDR(ADDR), .NUM_REGS(NREG)) u0 (
        .clk          (clk),
        .rst          (rst),
        .scl_in       (scl_m),
        .sda_in       (sda_bus),
        .sda_pull_low (pull),
        .bus_busy     (busy),
        .rd_index     (rd_index),
        .rd_data      (rd_data)
    );

    task automatic tick(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic check(input logic ok, input string tag, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
        end
    endtask

    task automatic put_bit(input logic b, output logic seen);
        sda_m = b;
        tick(Q);
        scl_m = 1'b1;
        tick(Q);
        seen = sda_bus;
        tick(Q);
        scl_m = 1'b0;
        tick(Q);
    endtask

    task automatic bus_start();
        sda_m = 1'b1;
        tick(Q);
        scl_m = 1'b1;
        tick(Q);
        sda_m = 1'b0;
        tick(Q);
        scl_m = 1'b0;
        tick(Q);
    endtask

    task automatic bus_stop();
        sda_m = 1'b0;
        tick(Q);
        scl_m = 1'b1;
        tick(Q);
        sda_m = 1'b1;
        tick(Q);
    endtask

    // driver: sends a byte and pushes expected/observed acknowledge into the scoreboard
    task automatic send_byte(input logic [7:0] b, input logic exp_ack, input string tag);
        logic seen;
        for (int i = 7; i >= 0; i--) put_bit(b[i], seen);
        put_bit(1'b1, seen);
        exp_q.push_back(exp_ack);
        got_q.push_back(!seen);
        tag_q.push_back(tag);
    endtask

    task automatic check_reg(input int idx, input string tag);
        rd_index = 4'(idx);
        tick(1);
        check(rd_data == model[idx], tag, rd_data, model[idx]);
    endtask

    // monitor: pops scoreboard entries as acknowledges are observed
    initial begin
        forever begin
            wait (got_q.size() > 0);
            begin
                logic  e;
                logic  g;
                string t;
                e = exp_q.pop_front();
                g = got_q.pop_front();
                t = tag_q.pop_front();
                check(e == g, t, g, e);
            end
        end
    end

    initial begin
        repeat (200000) @(posedge clk);
        errors++;
        checks++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        logic dummy;
        for (int i = 0; i < NREG; i++) model[i] = 8'h00;
        tick(5);
        rst = 1'b0;
        tick(5);

        // R11 reset state, R12 read port
        check(pull == 1'b0, "R11 pull after reset", pull, 0);
        check(busy == 1'b0, "R11 busy after reset", busy, 0);
        for (int i = 0; i < NREG; i++) check_reg(i, "R11 reg after reset");

        // R1..R3, R6, R7: burst write from pointer 3
        bus_start();
        check(busy == 1'b1, "R1 busy after start", busy, 1);
        send_byte({ADDR, 1'b0}, 1'b1, "R3 own address ack");
        send_byte(8'h03, 1'b1, "R6 pointer ack");
        send_byte(8'hA1, 1'b1, "R7 data ack 3");
        send_byte(8'hB2, 1'b1, "R7 data ack 4");
        send_byte(8'hC3, 1'b1, "R7 data ack 5");
        bus_stop();
        tick(5);
        check(busy == 1'b0, "R1 idle after stop", busy, 0);
        model[3] = 8'hA1; model[4] = 8'hB2; model[5] = 8'hC3;
        check_reg(3, "R2 R7 reg3 msb first");
        check_reg(4, "R7 reg4");
        check_reg(5, "R7 reg5");

        // R4: foreign address
        bus_start();
        send_byte({7'h15, 1'b0}, 1'b0, "R4 foreign address nack");
        send_byte(8'h00, 1'b0, "R4 ignored pointer");
        send_byte(8'h77, 1'b0, "R4 ignored data");
        bus_stop();
        check_reg(0, "R4 reg0 untouched");

        // R5: broadcast write
        bus_start();
        send_byte(8'h00, 1'b1, "R5 broadcast ack");
        send_byte(8'h00, 1'b1, "R5 pointer ack");
        send_byte(8'h5A, 1'b1, "R5 data ack");
        bus_stop();
        model[0] = 8'h5A;
        check_reg(0, "R5 reg0 written");

        // R8: burst runs past the end
        bus_start();
        send_byte({ADDR, 1'b0}, 1'b1, "R3 address ack");
        send_byte(8'h0E, 1'b1, "R6 pointer 14 ack");
        send_byte(8'hE1, 1'b1, "R7 reg14 ack");
        send_byte(8'hE2, 1'b1, "R7 reg15 ack");
        send_byte(8'hE3, 1'b0, "R8 overflow nack");
        send_byte(8'hE4, 1'b0, "R8 overflow nack again");
        bus_stop();
        model[14] = 8'hE1; model[15] = 8'hE2;
        check_reg(14, "R7 reg14");
        check_reg(15, "R7 reg15");
        check_reg(0, "R8 no wrap into reg0");
        check_reg(1, "R8 no wrap into reg1");

        // R6, R8: out-of-range pointer
        bus_start();
        send_byte({ADDR, 1'b0}, 1'b1, "R3 address ack");
        send_byte(8'h20, 1'b1, "R6 out-of-range pointer ack");
        send_byte(8'h99, 1'b0, "R8 data nack");
        bus_stop();

        // R9: repeated start mid-byte
        bus_start();
        send_byte({ADDR, 1'b0}, 1'b1, "R3 address ack");
        send_byte(8'h07, 1'b1, "R6 pointer ack");
        send_byte(8'h11, 1'b1, "R7 reg7 ack");
        put_bit(1'b1, dummy);
        put_bit(1'b0, dummy);
        put_bit(1'b1, dummy);
        bus_start();
        send_byte({ADDR, 1'b0}, 1'b1, "R9 address after restart ack");
        send_byte(8'h09, 1'b1, "R9 pointer after restart ack");
        send_byte(8'h33, 1'b1, "R9 data after restart ack");
        bus_stop();
        model[7] = 8'h11; model[9] = 8'h33;
        check_reg(7, "R7 reg7");
        check_reg(8, "R9 partial byte discarded");
        check_reg(9, "R9 reg9");

        // R10: read direction
        bus_start();
        send_byte({ADDR, 1'b1}, 1'b1, "R10 read address ack");
        send_byte(8'hFF, 1'b0, "R10 silent after read address");
        bus_stop();

        // final sweep
        for (int i = 0; i < NREG; i++) check_reg(i, "R12 final contents");

        wait (got_q.size() == 0);
        tick(2);
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

endmodule